// File: doc/BRIEF.md
# Lockable Module Configuration Register

This block is the configuration register of an embedded nonvolatile-memory controller. It holds six fields: a program/erase enable, a freeze-override control, a boot-vector disable, a lock, an array-space selector and a wait-state selector. A stop bit sits beside them. When reset is applied, the boot, lock, array-space and wait-state fields load from shadow-bit inputs rather than from constants. The stop bit comes out of reset set, so the module starts stopped and software can configure it before enabling it.

After reset, software reaches the register through a simple bus: a select, a write enable, write data and registered read data. The lock bit can only be set by software, never cleared, and so it protects the array-space and wait-state fields until the next reset. Those two fields accept writes only while the module is unlocked and stopped. The block also gates the program/erase high-voltage enable against a debug freeze input, and it decodes the wait-state field into a bus transfer length in clocks.

Top module: `nvm_cfg_reg`

## Requirements
- R1: During a cycle with `rst` high, the boot, lock, space and wait fields load from `shd_boot`, `shd_lock`, `shd_space` and `shd_wait`. In the same reset, stop is set to 1 and both the freeze-control and program/erase-enable bits are cleared to 0.
- R2: A write is a cycle with `sel` and `wr_en` both high. It updates the program/erase enable (bit 0), freeze control (bit 1) and stop (bit 8) fields from `wdata` at that clock edge.
- R3: Writing 1 to bit 3 sets the lock. Writing 0 to bit 3 never clears it. Only reset returns lock to the `shd_lock` value.
- R4: A write updates the space field (bits 5:4) and the wait field (bits 7:6) only if lock is 0 and stop is 1 before the write. In any other state these bits of the write are ignored.
- R5: The boot field (bit 2) is read-only. Writes never change it.
- R6: `hv_on` is registered. One cycle after inputs are sampled, it equals the program/erase enable AND (freeze control OR NOT `dbg_freeze`).
- R7: `xfer_clks` decodes the wait field as follows: 00 gives 3, 01 gives 4, 10 gives 5 and 11 gives 2.
- R8: `rdata` is registered. One cycle after a cycle with `sel` high, it shows the image {stop[8], wait[7:6], space[5:4], lock[3], boot[2], freeze control[1], pe enable[0]} with all higher bits 0. One cycle after a cycle with `sel` low, it is 0.
- R9: A cycle with `sel` low leaves every field unchanged, whatever `wr_en` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Address decode hit for this register |
| wr_en | input | 1 | Write strobe, qualified by sel |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| shd_boot | input | 1 | Shadow value for boot disable |
| shd_lock | input | 1 | Shadow value for lock |
| shd_space | input | 2 | Shadow value for array space |
| shd_wait | input | 2 | Shadow value for wait states |
| dbg_freeze | input | 1 | Debug freeze request |
| cfg_pe_en | output | 1 | Program/erase enable field |
| cfg_frz_ctl | output | 1 | Freeze-override control field |
| cfg_boot_dis | output | 1 | Boot-vector disable field |
| cfg_lock | output | 1 | Lock field |
| cfg_space | output | 2 | Array-space field |
| cfg_wait | output | 2 | Wait-state field |
| cfg_stop | output | 1 | Stop field |
| xfer_clks | output | 3 | Transfer length in clocks, decoded from the wait field |
| hv_on | output | 1 | Gated program/erase voltage enable |

## Verification
The assertions assume that the shadow inputs are steady during the cycles `rst` is high and that `rst` is held for at least one clock edge from time zero. They also assume that `wr_en` has no effect unless `sel` is asserted. The bench meets these assumptions by changing shadow values and bus signals only on the falling edge and by applying a full reset cycle before each new shadow set. It covers all 64 shadow combinations, every lock/stop pairing for protected writes, and all eight enable/override/freeze combinations.

// File: rtl/nvm_cfg_pkg.sv
package nvm_cfg_pkg;
  localparam int IMG_W = 9;

  // Field image as it appears on the bus, MSB first.
  typedef struct packed {
    logic       stop;
    logic [1:0] wt;
    logic [1:0] spc;
    logic       lock;
    logic       boot;
    logic       frz;
    logic       pe;
  } cfg_t;

  function automatic logic [2:0] wait_to_clks(input logic [1:0] w);
    logic [2:0] c;
    case (w)
      2'b00:   c = 3'd3;
      2'b01:   c = 3'd4;
      2'b10:   c = 3'd5;
      default: c = 3'd2;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nvm_cfg_fields.sv
module nvm_cfg_fields
  import nvm_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IMG_W-1:0] wimg,
  input  logic             shd_boot,
  input  logic             shd_lock,
  input  logic [1:0]       shd_spc,
  input  logic [1:0]       shd_wt,
  output cfg_t             cfg_q
);
  cfg_t w;
  logic prot_open;

  assign w         = cfg_t'(wimg);
  assign prot_open = !cfg_q.lock && cfg_q.stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.stop <= 1'b1;
      cfg_q.wt   <= shd_wt;
      cfg_q.spc  <= shd_spc;
      cfg_q.lock <= shd_lock;
      cfg_q.boot <= shd_boot;
      cfg_q.frz  <= 1'b0;
      cfg_q.pe   <= 1'b0;
    end else if (we) begin
      cfg_q.pe   <= w.pe;
      cfg_q.frz  <= w.frz;
      cfg_q.stop <= w.stop;
      if (w.lock) cfg_q.lock <= 1'b1;
      if (prot_open) begin
        cfg_q.spc <= w.spc;
        cfg_q.wt  <= w.wt;
      end
    end
  end
endmodule

// File: rtl/nvm_cfg_hvgate.sv
module nvm_cfg_hvgate (
  input  logic clk,
  input  logic rst,
  input  logic pe_en,
  input  logic frz_ctl,
  input  logic freeze,
  output logic hv_on
);
  always_ff @(posedge clk) begin
    if (rst) hv_on <= 1'b0;
    else     hv_on <= pe_en && (frz_ctl || !freeze);
  end
endmodule

// File: rtl/nvm_cfg_rdmux.sv
module nvm_cfg_rdmux
  import nvm_cfg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  cfg_t          img,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ext;

  always_comb begin
    ext = '0;
    ext[IMG_W-1:0] = img;
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (sel) rdata <= ext;
    else          rdata <= '0;
  end
endmodule

// File: rtl/nvm_cfg_reg.sv
module nvm_cfg_reg
  import nvm_cfg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          shd_boot,
  input  logic          shd_lock,
  input  logic [1:0]    shd_space,
  input  logic [1:0]    shd_wait,
  input  logic          dbg_freeze,
  output logic          cfg_pe_en,
  output logic          cfg_frz_ctl,
  output logic          cfg_boot_dis,
  output logic          cfg_lock,
  output logic [1:0]    cfg_space,
  output logic [1:0]    cfg_wait,
  output logic          cfg_stop,
  output logic [2:0]    xfer_clks,
  output logic          hv_on
);
  cfg_t cfg_q;

  generate
    if (DW < IMG_W) begin : g_bad_width
      initial $error("nvm_cfg_reg: DW must be at least %0d", IMG_W);
    end else if (DW > IMG_W) begin : g_hi_bits
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DW-1:IMG_W];
    end
  endgenerate

  nvm_cfg_fields u_fields (
    .clk      (clk),
    .rst      (rst),
    .we       (sel && wr_en),
    .wimg     (wdata[IMG_W-1:0]),
    .shd_boot (shd_boot),
    .shd_lock (shd_lock),
    .shd_spc  (shd_space),
    .shd_wt   (shd_wait),
    .cfg_q    (cfg_q)
  );

  nvm_cfg_hvgate u_hv (
    .clk     (clk),
    .rst     (rst),
    .pe_en   (cfg_q.pe),
    .frz_ctl (cfg_q.frz),
    .freeze  (dbg_freeze),
    .hv_on   (hv_on)
  );

  nvm_cfg_rdmux #(.DW(DW)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .img   (cfg_q),
    .rdata (rdata)
  );

  assign cfg_pe_en    = cfg_q.pe;
  assign cfg_frz_ctl  = cfg_q.frz;
  assign cfg_boot_dis = cfg_q.boot;
  assign cfg_lock     = cfg_q.lock;
  assign cfg_space    = cfg_q.spc;
  assign cfg_wait     = cfg_q.wt;
  assign cfg_stop     = cfg_q.stop;
  assign xfer_clks    = wait_to_clks(cfg_q.wt);
endmodule

// File: rtl/nvm_cfg_reg_chk.sv
module nvm_cfg_reg_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sel,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          shd_boot,
  input logic          shd_lock,
  input logic [1:0]    shd_space,
  input logic [1:0]    shd_wait,
  input logic          dbg_freeze,
  input logic          cfg_pe_en,
  input logic          cfg_frz_ctl,
  input logic          cfg_boot_dis,
  input logic          cfg_lock,
  input logic [1:0]    cfg_space,
  input logic [1:0]    cfg_wait,
  input logic          cfg_stop,
  input logic [2:0]    xfer_clks,
  input logic          hv_on
);
  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> cfg_stop && !cfg_pe_en && !cfg_frz_ctl && !hv_on
            && cfg_lock == $past(shd_lock) && cfg_boot_dis == $past(shd_boot)
            && cfg_space == $past(shd_space) && cfg_wait == $past(shd_wait));

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_lock |=> cfg_lock);

  a_r4_protected_hold: assert property (@(posedge clk) disable iff (rst)
    (!sel || !wr_en || cfg_lock || !cfg_stop) |=> $stable(cfg_space) && $stable(cfg_wait));

  a_r4_protected_take: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && !cfg_lock && cfg_stop) |=>
      cfg_space == $past(wdata[5:4]) && cfg_wait == $past(wdata[7:6]));

  a_r5_boot_readonly: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg_boot_dis));

  a_r6_freeze_blocks: assert property (@(posedge clk) disable iff (rst)
    (dbg_freeze && !cfg_frz_ctl) |=> !hv_on);

  a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !cfg_pe_en |=> !hv_on);

  a_r7_fast_term: assert property (@(posedge clk) disable iff (rst)
    (cfg_wait == 2'b11) |-> xfer_clks == 3'd2);

  a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !sel |=> rdata == '0);

  a_r9_unselected_hold: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(cfg_pe_en) && $stable(cfg_frz_ctl) && $stable(cfg_stop)
             && $stable(cfg_lock));
endmodule

bind nvm_cfg_reg nvm_cfg_reg_chk #(.DW(DW)) chk_i (.*);

// File: tb/nvm_cfg_reg_tb.sv
module nvm_cfg_reg_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          shd_boot = 1'b0, shd_lock = 1'b0, dbg_freeze = 1'b0;
  logic [1:0]    shd_space = 2'b10, shd_wait = 2'b00;
  logic          cfg_pe_en, cfg_frz_ctl, cfg_boot_dis, cfg_lock, cfg_stop, hv_on;
  logic [1:0]    cfg_space, cfg_wait;
  logic [2:0]    xfer_clks;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvm_cfg_reg #(.DW(DW)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int img(input int pe, frz, boot, lock, spc, wt, stop);
    return pe | (frz << 1) | (boot << 2) | (lock << 3) | (spc << 4) | (wt << 6) | (stop << 8);
  endfunction

  function automatic int clks(input int w);
    return (w == 3) ? 2 : 3 + w;
  endfunction

  task automatic do_reset(input int s);
    @(negedge clk);
    rst = 1'b1; sel = 1'b0; wr_en = 1'b0;
    shd_boot = s[0]; shd_lock = s[1]; shd_space = s[3:2]; shd_wait = s[5:4];
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int d);
    sel = 1'b1; wr_en = 1'b1; wdata = DW'(d);
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(output int v);
    sel = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    v = int'(rdata);
    sel = 1'b0;
  endtask

  initial begin
    int v;
    // R1, R7, R8: every shadow combination
    for (int s = 0; s < 64; s++) begin
      do_reset(s);
      check("R1 lock", cfg_lock, s[1]);
      check("R1 stop", cfg_stop, 1);
      check("R1 hv", hv_on, 0);
      check("R7 xfer", xfer_clks, clks(s[5:4]));
      rd(v);
      check("R8 image", v, img(0, 0, s[0], s[1], s[3:2], s[5:4], 1));
      @(negedge clk);
      check("R8 idle zero", int'(rdata), 0);
    end

    // R4: protected writes across lock/stop states
    for (int l = 0; l < 2; l++) begin
      for (int st = 0; st < 2; st++) begin
        do_reset(8 | (l << 1));            // space=2, wait=0, boot=0
        wr(img(0, 0, 0, 0, 2, 0, st));
        wr(img(0, 0, 0, 0, 3, 3, st));
        check("R4 space", cfg_space, (l == 0 && st == 1) ? 3 : 2);
        check("R4 wait", cfg_wait, (l == 0 && st == 1) ? 3 : 0);
        check("R2 stop", cfg_stop, st);
      end
    end

    // R3, R5, R9
    do_reset(1);                           // boot=1, lock=0, space=0, wait=0
    wr(img(0, 0, 0, 1, 1, 2, 1));
    check("R3 lock set", cfg_lock, 1);
    check("R4 pre-lock write", cfg_space, 1);
    check("R5 boot", cfg_boot_dis, 1);
    wr(img(0, 0, 0, 0, 3, 0, 1));
    check("R3 lock held", cfg_lock, 1);
    check("R4 locked space", cfg_space, 1);
    check("R4 locked wait", cfg_wait, 2);
    sel = 1'b0; wr_en = 1'b1; wdata = DW'(img(1, 1, 0, 0, 0, 0, 0));
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    rd(v);
    check("R9 unselected", v, img(0, 0, 1, 1, 1, 2, 1));
    do_reset(0);
    check("R3 reset clears", cfg_lock, 0);

    // R2, R6: enable / override / freeze
    for (int c = 0; c < 8; c++) begin
      do_reset(8);
      wr(img(c & 1, (c >> 1) & 1, 0, 0, 2, 0, 1));
      dbg_freeze = c[2];
      @(negedge clk);
      @(negedge clk);
      check("R2 frz", cfg_frz_ctl, (c >> 1) & 1);
      check("R2 pe", cfg_pe_en, c & 1);
      check("R6 hv", hv_on, ((c & 1) != 0 && (((c >> 1) & 1) != 0 || c[2] == 0)) ? 1 : 0);
      dbg_freeze = 1'b0;
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule